// File: doc/BRIEF.md
# Warp Load Coalescer

This block takes a single load issued by a group of parallel lanes. Each lane offers a byte address and an active flag. Memory is split into equal, aligned burst sections, and any fetch returns a whole section. The block finds the distinct sections that the active lanes touch. It sends one request per section to a memory-side port with a valid/ready handshake. Each returned section is used to fill every lane that needs it.

Sections are picked by a priority scan. Each scan starts at the lowest-numbered active lane that is still unserved, and every lane whose address falls in that section is marked served. Only one section request is outstanding at a time. When the last section has arrived, the block raises a one-cycle completion pulse. All lane words are valid at that point, together with the number of requests the load cost. No new load is taken until then. Lane count, address width, section size and word size are parameters.

Top module: `warp_coalescer`

## Requirements
- R1: After reset, ld_ready is 1, mem_req_valid is 0, done is 0, req_count is 0 and lane_data is all zero.
- R2: A request carries the section index, which is the lane byte address shifted right by log2(SECT_BYTES).
- R3: When all active lanes fall in one section, exactly one request is issued for the load.
- R4: A load issues exactly one request for each distinct section touched by its active lanes, and never repeats a section.
- R5: Requests are issued in ascending order of the lowest-numbered lane that each request serves.
- R6: While mem_req_valid is high and mem_req_ready is low, mem_req_valid stays high and mem_req_sect stays unchanged.
- R7: Each active lane receives the WORD_BYTES-wide word at its byte offset within the returned section. Lane i occupies lane_data bits [i*WORD_W +: WORD_W], and word k of a section occupies mem_rsp_data bits [k*WORD_W +: WORD_W]. Other bytes of the section reach no lane.
- R8: Inactive lanes generate no request and report a zero word.
- R9: A load with no active lane issues no request and raises done in the cycle after it is accepted, with req_count equal to 0.
- R10: A load is accepted when ld_valid and ld_ready are both high. ld_ready stays low from acceptance through the done cycle, so a load offered during that time is ignored. done is a one-cycle pulse. lane_data and req_count stay unchanged after done until the next load is accepted.
- R11: req_count, valid with done, equals the number of requests handshaked for that load.
- R12: No new request is raised while a previously accepted request still awaits its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | A warp load is offered |
| ld_ready | output | 1 | Block can accept a load |
| ld_active | input | LANES | Per-lane active flags |
| ld_addr | input | LANES*ADDR_W | Per-lane byte addresses, lane i at [i*ADDR_W +: ADDR_W] |
| mem_req_valid | output | 1 | Section request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_sect | output | ADDR_W-log2(SECT_BYTES) | Requested section index |
| mem_rsp_valid | input | 1 | Section data returned |
| mem_rsp_data | input | SECT_BYTES*8 | Whole section, byte k at [k*8 +: 8] |
| done | output | 1 | One-cycle completion pulse |
| lane_data | output | LANES*WORD_BYTES*8 | Per-lane returned words |
| req_count | output | clog2(LANES+1) | Requests issued for the last load |

## Verification
The block is exercised with several address patterns:
- Unit-stride aligned addresses check that a load costs one request.
- A stride of three bytes and a misaligned base check that the block splits into exactly the sections touched, no more.
- Lanes interleaved across two sections, and a pattern where a higher lane holds a lower section, separate lowest-lane ordering from ascending-address ordering.
- All lanes on one address, and sparse active masks, check that sections are merged and inactive lanes are zeroed.
- An all-inactive load checks the path that completes without any request.

Back-pressure on the request port and varied response latency show that the request is held steady and that only one request is in flight at a time.

// File: rtl/wc_pkg.sv
package wc_pkg;
   typedef enum logic [1:0] {
      WC_IDLE  = 2'd0,
      WC_ISSUE = 2'd1,
      WC_WAIT  = 2'd2,
      WC_DONE  = 2'd3
   } wc_state_e;
endpackage

// File: rtl/wc_first_pick.sv
// Priority scan: section of the lowest pending lane, and every pending lane sharing it.
module wc_first_pick #(
   parameter int LANES  = 4,
   parameter int SECT_W = 6
) (
   input  logic [LANES-1:0]        pend,
   input  logic [LANES*SECT_W-1:0] sect_flat,
   output logic                    any_pend,
   output logic [SECT_W-1:0]       pick_sect,
   output logic [LANES-1:0]        hit
);
   always_comb begin
      any_pend  = 1'b0;
      pick_sect = '0;
      for (int i = LANES - 1; i >= 0; i--) begin
         if (pend[i]) begin
            any_pend  = 1'b1;
            pick_sect = sect_flat[i*SECT_W +: SECT_W];
         end
      end
   end

   for (genvar g = 0; g < LANES; g++) begin : g_hit
      assign hit[g] = pend[g] && (sect_flat[g*SECT_W +: SECT_W] == pick_sect);
   end
endmodule

// File: rtl/wc_word_extract.sv
// Selects each lane's word from a returned section by its offset inside the section.
module wc_word_extract #(
   parameter int LANES      = 4,
   parameter int ADDR_W     = 8,
   parameter int SECT_BYTES = 4,
   parameter int WORD_BYTES = 1
) (
   input  logic [SECT_BYTES*8-1:0]       sect_data,
   input  logic [LANES*ADDR_W-1:0]       addr_flat,
   output logic [LANES*WORD_BYTES*8-1:0] words
);
   localparam int WORD_W = WORD_BYTES * 8;
   localparam int WPS    = SECT_BYTES / WORD_BYTES;
   localparam int WB_W   = $clog2(WORD_BYTES);
   localparam int WIX_W  = (WPS > 1) ? $clog2(WPS) : 1;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      if (WPS == 1) begin : g_whole
         assign words[g*WORD_W +: WORD_W] = sect_data;
      end else begin : g_slice
         logic [WIX_W-1:0] widx;
         assign widx = addr_flat[g*ADDR_W + WB_W +: WIX_W];
         assign words[g*WORD_W +: WORD_W] = sect_data[widx*WORD_W +: WORD_W];
      end
   end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
   import wc_pkg::*;
#(
   parameter int  LANES      = 4,
   parameter int  ADDR_W     = 8,
   parameter int  SECT_BYTES = 4,
   parameter int  WORD_BYTES = 1,
   localparam int OFS_W      = $clog2(SECT_BYTES),
   localparam int SECT_W     = ADDR_W - OFS_W,
   localparam int WORD_W     = WORD_BYTES * 8,
   localparam int CNT_W      = $clog2(LANES + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ld_valid,
   output logic                    ld_ready,
   input  logic [LANES-1:0]        ld_active,
   input  logic [LANES*ADDR_W-1:0] ld_addr,
   output logic                    mem_req_valid,
   input  logic                    mem_req_ready,
   output logic [SECT_W-1:0]       mem_req_sect,
   input  logic                    mem_rsp_valid,
   input  logic [SECT_BYTES*8-1:0] mem_rsp_data,
   output logic                    done,
   output logic [LANES*WORD_W-1:0] lane_data,
   output logic [CNT_W-1:0]        req_count
);
   // elaboration-time parameter checks
   if ((SECT_BYTES & (SECT_BYTES - 1)) != 0 || SECT_BYTES < 1) begin : g_bad_sect
      $error("SECT_BYTES must be a power of two");
   end
   if ((WORD_BYTES & (WORD_BYTES - 1)) != 0 || WORD_BYTES > SECT_BYTES) begin : g_bad_word
      $error("WORD_BYTES must be a power of two not above SECT_BYTES");
   end
   if (ADDR_W <= OFS_W) begin : g_bad_addr
      $error("ADDR_W must exceed log2(SECT_BYTES)");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("LANES must be at least one");
   end

   wc_state_e                 state_q;
   logic [LANES*ADDR_W-1:0]   addr_q;
   logic [LANES-1:0]          pend_q;
   logic [LANES*WORD_W-1:0]   data_q;
   logic [CNT_W-1:0]          cnt_q;

   logic [LANES*SECT_W-1:0]   sect_flat;
   logic                      any_pend;
   logic [SECT_W-1:0]         pick_sect;
   logic [LANES-1:0]          hit;
   logic [LANES*WORD_W-1:0]   words;
   logic [LANES-1:0]          pend_left;

   for (genvar g = 0; g < LANES; g++) begin : g_sect
      assign sect_flat[g*SECT_W +: SECT_W] = addr_q[g*ADDR_W + OFS_W +: SECT_W];
   end

   wc_first_pick #(
      .LANES (LANES),
      .SECT_W(SECT_W)
   ) u_pick (
      .pend     (pend_q),
      .sect_flat(sect_flat),
      .any_pend (any_pend),
      .pick_sect(pick_sect),
      .hit      (hit)
   );

   wc_word_extract #(
      .LANES     (LANES),
      .ADDR_W    (ADDR_W),
      .SECT_BYTES(SECT_BYTES),
      .WORD_BYTES(WORD_BYTES)
   ) u_extract (
      .sect_data(mem_rsp_data),
      .addr_flat(addr_q),
      .words    (words)
   );

   assign pend_left = pend_q & ~hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= WC_IDLE;
         addr_q  <= '0;
         pend_q  <= '0;
         data_q  <= '0;
         cnt_q   <= '0;
      end else begin
         case (state_q)
            WC_IDLE: begin
               if (ld_valid) begin
                  addr_q  <= ld_addr;
                  pend_q  <= ld_active;
                  data_q  <= '0;
                  cnt_q   <= '0;
                  state_q <= (|ld_active) ? WC_ISSUE : WC_DONE;
               end
            end
            WC_ISSUE: begin
               if (mem_req_ready && any_pend) begin
                  cnt_q   <= cnt_q + CNT_W'(1);
                  state_q <= WC_WAIT;
               end
            end
            WC_WAIT: begin
               if (mem_rsp_valid) begin
                  for (int i = 0; i < LANES; i++) begin
                     if (hit[i]) data_q[i*WORD_W +: WORD_W] <= words[i*WORD_W +: WORD_W];
                  end
                  pend_q  <= pend_left;
                  state_q <= (pend_left == '0) ? WC_DONE : WC_ISSUE;
               end
            end
            default: state_q <= WC_IDLE;
         endcase
      end
   end

   assign ld_ready      = (state_q == WC_IDLE);
   assign mem_req_valid = (state_q == WC_ISSUE) && any_pend;
   assign mem_req_sect  = pick_sect;
   assign done          = (state_q == WC_DONE);
   assign lane_data     = data_q;
   assign req_count     = cnt_q;
endmodule

// File: rtl/wc_checker.sv
module wc_checker #(
   parameter int LANES  = 4,
   parameter int SECT_W = 6,
   parameter int CNT_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ld_valid,
   input logic              ld_ready,
   input logic [LANES-1:0]  ld_active,
   input logic              mem_req_valid,
   input logic              mem_req_ready,
   input logic [SECT_W-1:0] mem_req_sect,
   input logic              mem_rsp_valid,
   input logic              done,
   input logic [CNT_W-1:0]  req_count
);
   logic             outst_q;
   logic [CNT_W-1:0] hs_cnt_q;
   logic [LANES-1:0] act_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         outst_q  <= 1'b0;
         hs_cnt_q <= '0;
         act_q    <= '0;
      end else begin
         if (ld_valid && ld_ready) begin
            hs_cnt_q <= '0;
            act_q    <= ld_active;
         end else if (mem_req_valid && mem_req_ready) begin
            hs_cnt_q <= hs_cnt_q + CNT_W'(1);
         end
         if (mem_req_valid && mem_req_ready) outst_q <= 1'b1;
         else if (mem_rsp_valid)             outst_q <= 1'b0;
      end
   end

   a_r6_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_sect));

   a_r12_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
      outst_q |-> !mem_req_valid);

   a_r10_busy_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !ld_ready);

   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r11_count_matches: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> req_count == hs_cnt_q);

   a_r9_empty_load: assert property (@(posedge clk) disable iff (!rst_n)
      done && (act_q == '0) |-> req_count == '0);

   a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> int'(req_count) <= $countones(act_q));
endmodule

bind warp_coalescer wc_checker #(
   .LANES (LANES),
   .SECT_W(SECT_W),
   .CNT_W (CNT_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ld_valid     (ld_valid),
   .ld_ready     (ld_ready),
   .ld_active    (ld_active),
   .mem_req_valid(mem_req_valid),
   .mem_req_ready(mem_req_ready),
   .mem_req_sect (mem_req_sect),
   .mem_rsp_valid(mem_rsp_valid),
   .done         (done),
   .req_count    (req_count)
);

// File: tb/warp_coalescer_tb.sv
module warp_coalescer_tb;
   localparam int CLK_PERIOD = 10;
   localparam int LANES  = 4;
   localparam int ADDR_W = 8;
   localparam int SECT_W = 6;
   localparam int CNT_W  = 3;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic                    ld_valid = 1'b0;
   logic                    ld_ready;
   logic [LANES-1:0]        ld_active = '0;
   logic [LANES*ADDR_W-1:0] ld_addr = '0;
   logic                    mem_req_valid;
   logic                    mem_req_ready = 1'b1;
   logic [SECT_W-1:0]       mem_req_sect;
   logic                    mem_rsp_valid = 1'b0;
   logic [31:0]             mem_rsp_data = '0;
   logic                    done;
   logic [LANES*8-1:0]      lane_data;
   logic [CNT_W-1:0]        req_count;

   int nchk = 0;
   int nfail = 0;
   bit finished = 0;

   // reference model state
   logic [SECT_W-1:0] exp_q[$];
   logic [7:0]        exp_data[LANES];
   int                exp_cnt;
   int                latency = 0;
   int                stall_mod = 0;
   int                cyc = 0;
   bit                have_req = 0;
   int                lat_cnt = 0;
   logic [SECT_W-1:0] req_sect;
   bit                hold_pend = 0;
   logic [SECT_W-1:0] hold_sect;

   always #(CLK_PERIOD/2) clk = ~clk;

   warp_coalescer u_dut (
      .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
      .ld_active(ld_active), .ld_addr(ld_addr), .mem_req_valid(mem_req_valid),
      .mem_req_ready(mem_req_ready), .mem_req_sect(mem_req_sect),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .done(done),
      .lane_data(lane_data), .req_count(req_count)
   );

   function automatic logic [7:0] mem_byte(logic [7:0] a);
      return 8'(a * 37 + 11);
   endfunction

   function automatic logic [31:0] sect_bytes(logic [SECT_W-1:0] s);
      logic [31:0] r;
      for (int k = 0; k < 4; k++) r[k*8 +: 8] = mem_byte({s, 2'(k)});
      return r;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // memory responder and per-clock comparison with the model
   always @(negedge clk) begin
      if (rst_n) begin
         cyc++;
         if (have_req && mem_req_valid)
            chk(0, "R12 request while one outstanding", 1, 0);
         mem_rsp_valid = 1'b0;
         if (have_req) begin
            if (lat_cnt == 0) begin
               mem_rsp_valid = 1'b1;
               mem_rsp_data  = sect_bytes(req_sect);
               have_req      = 0;
            end else lat_cnt--;
         end
         if (hold_pend) begin
            chk(mem_req_valid && mem_req_sect == hold_sect, "R6 stalled request held",
                {mem_req_valid, mem_req_sect}, {1'b1, hold_sect});
            hold_pend = 0;
         end
         mem_req_ready = (stall_mod == 0) ? 1'b1 : ((cyc % stall_mod) != 0);
         if (mem_req_valid) begin
            if (mem_req_ready) begin
               if (exp_q.size() == 0) begin
                  chk(0, "R4 extra request", mem_req_sect, 0);
               end else begin
                  chk(mem_req_sect == exp_q[0], "R2 R5 request section and order",
                      mem_req_sect, exp_q[0]);
                  void'(exp_q.pop_front());
               end
               have_req = 1;
               req_sect = mem_req_sect;
               lat_cnt  = latency;
            end else begin
               hold_pend = 1;
               hold_sect = mem_req_sect;
            end
         end
         if (done) begin
            chk(int'(req_count) == exp_cnt, "R11 R3 request count", req_count, exp_cnt);
            chk(exp_q.size() == 0, "R4 all sections requested", exp_q.size(), 0);
            for (int i = 0; i < LANES; i++)
               chk(lane_data[i*8 +: 8] == exp_data[i], "R7 R8 lane word",
                   lane_data[i*8 +: 8], exp_data[i]);
         end
      end
   end

   task automatic run_load(input logic [31:0] addrs, input logic [3:0] act,
                           input int lat, input int stall);
      logic [3:0] served = '0;
      int waited = 0;
      bit got = 0;
      @(negedge clk);
      chk(ld_ready, "R10 ready when idle", ld_ready, 1);
      exp_q.delete();
      for (int i = 0; i < LANES; i++) begin
         exp_data[i] = act[i] ? mem_byte(addrs[i*8 +: 8]) : 8'h00;
         if (act[i] && !served[i]) begin
            exp_q.push_back(addrs[i*8+2 +: 6]);
            for (int j = i; j < LANES; j++)
               if (act[j] && addrs[j*8+2 +: 6] == addrs[i*8+2 +: 6]) served[j] = 1'b1;
         end
      end
      exp_cnt   = exp_q.size();
      latency   = lat;
      stall_mod = stall;
      ld_addr   = addrs;
      ld_active = act;
      ld_valid  = 1'b1;
      @(negedge clk);
      ld_addr   = ~addrs;     // offered while busy: must be ignored
      ld_active = 4'hf;
      while (waited < 200 && !got) begin
         waited++;
         chk(!ld_ready, "R10 busy until done", ld_ready, 0);
         if (done) got = 1;
         else @(negedge clk);
      end
      ld_valid = 1'b0;
      chk(got, "R10 done reached", got, 1);
      if (act == 4'h0) chk(waited == 1, "R9 empty load completes next cycle", waited, 1);
      @(negedge clk);
      chk(!done && ld_ready, "R10 done is a pulse", {done, ld_ready}, 2'b01);
      for (int i = 0; i < LANES; i++)
         chk(lane_data[i*8 +: 8] == exp_data[i], "R10 lane data held", lane_data[i*8 +: 8], exp_data[i]);
      chk(int'(req_count) == exp_cnt, "R10 count held", req_count, exp_cnt);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(ld_ready == 1'b1, "R1 reset ld_ready", ld_ready, 1);
      chk(mem_req_valid == 1'b0, "R1 reset mem_req_valid", mem_req_valid, 0);
      chk(done == 1'b0, "R1 reset done", done, 0);
      chk(req_count == '0, "R1 reset req_count", req_count, 0);
      chk(lane_data == '0, "R1 reset lane_data", lane_data, 0);
      rst_n = 1'b1;
      // R3: unit stride, aligned base: one request
      run_load({8'd3, 8'd2, 8'd1, 8'd0}, 4'hf, 0, 0);
      // R4: stride of three bytes: sections 0,1,2
      run_load({8'd9, 8'd6, 8'd3, 8'd0}, 4'hf, 1, 0);
      // R4: misaligned base splits into two sections
      run_load({8'd5, 8'd4, 8'd3, 8'd2}, 4'hf, 0, 0);
      // R9: all inactive
      run_load({8'd40, 8'd30, 8'd20, 8'd10}, 4'h0, 0, 0);
      // R5 R8: higher lane holds lower section, sparse mask
      run_load({8'd20, 8'd8, 8'd100, 8'd40}, 4'b1010, 2, 0);
      // R3: all lanes on one address
      run_load({8'd77, 8'd77, 8'd77, 8'd77}, 4'hf, 0, 0);
      // R5: interleaved sections A,B,A,B
      run_load({8'd201, 8'd50, 8'd202, 8'd48}, 4'hf, 0, 0);
      // R6 R12: back-pressure and long latency, high addresses
      run_load({8'd255, 8'd128, 8'd254, 8'd12}, 4'hf, 3, 2);
      run_load({8'd16, 8'd250, 8'd33, 8'd7}, 4'b1101, 1, 3);
      // R7: single active lane at last byte of a section
      run_load({8'd0, 8'd0, 8'd0, 8'd63}, 4'b0001, 0, 2);
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         nchk++;
         nfail++;
         $display("FAIL watchdog expired actual=hung expected=complete");
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end
endmodule